// File: doc/BRIEF.md
# Receive DMA Request Generator

This block produces the active-low DMA request line for the receive side of a serial controller. It contains a small receive holding FIFO. Each stored character carries a flag that marks a special receive condition, such as a parity error or an overrun. While the function is selected and enabled, the request line is pulled low whenever a character is waiting. It is released when the host reads the receive data buffer, so a DMA engine can drain received characters one at a time.

Three bits of the channel control register gate the function.

The receive interrupt mode decides what happens to a flagged character:
- In the two modes that stop on special conditions, a flagged character is not removed when it is read. It stays locked at the head of the FIFO, and the request line is held inactive until an error-reset command releases and discards it.
- Exactly one request falling edge is given per character, including a locked one that is read repeatedly.

Top module: `rx_dma_req`

## Requirements
- R1: After reset `req_n_o` is 1, the FIFO is empty (`fifo_count_o` 0, `fifo_empty_o` 1, `fifo_full_o` 0).
- R2: `dma_ctrl_i` is control bits 7:5 as [2]=enable, [1]=request function select, [0]=receive direction. Unless all three are 1, `req_n_o` is 1 one clock later, whatever the FIFO holds.
- R3: With `dma_ctrl_i`=3'b111 and no read event, `req_n_o` is 0 in the clock after `fifo_count_o` is nonzero and the FIFO is not locked. `req_n_o` is never 0 while the FIFO is empty.
- R4: A read event is a cycle where `rd_n_i` is 0, `rd_n_i` was 1 in the previous cycle, and `rd_sel_i` is 1. A read event sets `req_n_o` to 1 on the next clock and removes the head entry, unless that entry locks under R7.
- R5: A falling `rd_n_i` with `rd_sel_i` 0 pops nothing and leaves `req_n_o` unchanged.
- R6: After a read event, if characters remain, `req_n_o` returns to 0 one clock after it went to 1, giving one falling edge per character.
- R7: For `rx_int_mode_i` 2'b01 (first character or special) or 2'b11 (special only), a read event on a head entry with its special flag set leaves the entry in place and locks the FIFO. While locked, `req_n_o` is 1 and further reads pop nothing.
- R8: `err_reset_i` while locked pops the head entry and unlocks in the same clock. From the next clock on, `req_n_o` follows occupancy again. `err_reset_i` while unlocked has no effect.
- R9: For `rx_int_mode_i` 2'b00 or 2'b10 a flagged head entry is popped by a read event like any other.
- R10: A push in the same cycle as a read event that empties the FIFO leaves one entry. `req_n_o` goes 1 and then 0 on the following two clocks.
- R11: The FIFO holds DEPTH (default 3) entries. A push while full with no pop in that cycle is dropped. `fifo_full_o` and `fifo_empty_o` reflect the count.
- R12: `rd_data_o` and `rd_err_o` show the head entry's character and special flag whenever the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_ctrl_i | input | 3 | Control bits 7:5: enable, function select, receive direction |
| rx_int_mode_i | input | 2 | Receive interrupt mode |
| rd_n_i | input | 1 | Host read strobe, active low |
| rd_sel_i | input | 1 | Host access targets the receive data buffer |
| push_i | input | 1 | Receiver writes a character |
| push_data_i | input | DATA_W | Character written |
| push_err_i | input | 1 | Character has a special receive condition |
| err_reset_i | input | 1 | Error-reset command, one-cycle pulse |
| rd_data_o | output | DATA_W | Head character |
| rd_err_o | output | 1 | Head special-condition flag |
| req_n_o | output | 1 | DMA request, active low |
| fifo_count_o | output | CNT_W | Entries held |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_full_o | output | 1 | FIFO full |

## Verification
The bench builds the block with its defaults, DATA_W 8 and DEPTH 3. The small depth lets a few pushes reach the full and drop case. It also lets the random phase often hit reads, locks and error resets that coincide with a full or nearly empty FIFO. It runs all four interrupt modes, so both the locking and the non-locking treatment of flagged characters are compared against the queue model.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  typedef enum logic [1:0] {
    RXI_OFF              = 2'b00,
    RXI_FIRST_OR_SPECIAL = 2'b01,
    RXI_ALL_CHARS        = 2'b10,
    RXI_SPECIAL_ONLY     = 2'b11
  } rx_int_mode_e;

  localparam int CTRL_EN  = 2;
  localparam int CTRL_FN  = 1;
  localparam int CTRL_DIR = 0;

  function automatic logic locks_on_special(rx_int_mode_e m);
    return (m == RXI_FIRST_OR_SPECIAL) || (m == RXI_SPECIAL_ONLY);
  endfunction
endpackage

// File: rtl/rx_dma_rd_detect.sv
module rx_dma_rd_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_n_i,
  input  logic rd_sel_i,
  output logic rd_evt_o
);
  logic rd_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_n_q <= 1'b1;
    else         rd_n_q <= rd_n_i;
  end

  assign rd_evt_o = rd_n_q & ~rd_n_i & rd_sel_i;
endmodule

// File: rtl/rx_dma_fifo.sv
module rx_dma_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_err_i,
  input  logic              rd_evt_i,
  input  logic              lock_mode_i,
  input  logic              err_reset_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_err_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              lock_o,
  output logic              lock_set_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  err_q;
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              lock_q;
  logic              empty, full, pop, push_ok, unlock;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty       = (count_q == '0);
  assign full        = (count_q == CNT_W'(DEPTH));
  assign head_data_o = data_q[rd_ptr_q];
  assign head_err_o  = err_q[rd_ptr_q];

  // locked head: a read returns data but does not remove it
  assign lock_set_o = rd_evt_i & ~empty & ~lock_q & head_err_o & lock_mode_i;
  assign unlock     = err_reset_i & lock_q;
  assign pop        = (rd_evt_i & ~empty & ~lock_q & ~(head_err_o & lock_mode_i)) | unlock;
  assign push_ok    = push_i & (~full | pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[i] <= '0;
        err_q[i]  <= 1'b0;
      end else if (push_ok && wr_ptr_q == PTR_W'(i)) begin
        data_q[i] <= push_data_i;
        err_q[i]  <= push_err_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)     rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (lock_set_o)  lock_q <= 1'b1;
      else if (unlock) lock_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign lock_o  = lock_q;

  a_r11_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r8_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && err_reset_i |=> !lock_q);
  a_r7_lock_keeps_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !err_reset_i |=> $stable(rd_ptr_q));
endmodule

// File: rtl/rx_dma_req_ctrl.sv
module rx_dma_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic rd_evt_i,
  input  logic lock_i,
  input  logic lock_set_i,
  input  logic has_data_i,
  output logic req_n_o
);
  logic req_q, req_d;

  // a read always releases; re-assertion waits one clock for updated occupancy
  assign req_d = active_i & ~rd_evt_i & ~lock_i & ~lock_set_i & has_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_n_o = ~req_q;

  a_r2_off_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> req_n_o);
  a_r4_read_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_i |=> req_n_o);
  a_r3_req_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_n_o |-> has_data_i);
endmodule

// File: rtl/rx_dma_req.sv
module rx_dma_req
  import rx_dma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        dma_ctrl_i,
  input  logic [1:0]        rx_int_mode_i,
  input  logic              rd_n_i,
  input  logic              rd_sel_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_err_i,
  input  logic              err_reset_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_err_o,
  output logic              req_n_o,
  output logic [CNT_W-1:0]  fifo_count_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o
);
  logic rd_evt, lock, lock_set, active, lock_mode;
  logic [CNT_W-1:0] count;

  assign active    = dma_ctrl_i[CTRL_EN] & dma_ctrl_i[CTRL_FN] & dma_ctrl_i[CTRL_DIR];
  assign lock_mode = locks_on_special(rx_int_mode_e'(rx_int_mode_i));

  rx_dma_rd_detect u_rd (
    .clk_i, .rst_ni, .rd_n_i, .rd_sel_i, .rd_evt_o(rd_evt)
  );

  rx_dma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni, .push_i, .push_data_i, .push_err_i,
    .rd_evt_i(rd_evt), .lock_mode_i(lock_mode), .err_reset_i,
    .head_data_o(rd_data_o), .head_err_o(rd_err_o), .count_o(count),
    .lock_o(lock), .lock_set_o(lock_set)
  );

  rx_dma_req_ctrl u_ctrl (
    .clk_i, .rst_ni, .active_i(active), .rd_evt_i(rd_evt), .lock_i(lock),
    .lock_set_i(lock_set), .has_data_i(count != '0), .req_n_o
  );

  assign fifo_count_o = count;
  assign fifo_empty_o = (count == '0);
  assign fifo_full_o  = (count == CNT_W'(DEPTH));

  a_r7_locked_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> req_n_o);
endmodule

// File: tb/tb_rx_dma_req.sv
module tb_rx_dma_req;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 3;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] dma_ctrl = 3'b000;
  logic [1:0] mode = 2'b00;
  logic rd_n = 1'b1, rd_sel = 1'b0, push = 1'b0, push_err = 1'b0, err_reset = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_err, req_n, empty, full;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  rx_dma_req #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dma_ctrl_i(dma_ctrl), .rx_int_mode_i(mode),
    .rd_n_i(rd_n), .rd_sel_i(rd_sel), .push_i(push), .push_data_i(push_data),
    .push_err_i(push_err), .err_reset_i(err_reset), .rd_data_o(rd_data),
    .rd_err_o(rd_err), .req_n_o(req_n), .fifo_count_o(count),
    .fifo_empty_o(empty), .fifo_full_o(full)
  );

  // behavioural reference
  logic [DATA_W:0] m_q[$];
  bit m_lock, m_req, m_rd_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_lock = 0; m_req = 0; m_rd_prev = 1;
    end else begin
      bit act, evt, lmode, setl, pp;
      act   = (dma_ctrl == 3'b111);
      evt   = m_rd_prev && !rd_n && rd_sel;
      lmode = (mode == 2'b01) || (mode == 2'b11);
      setl = 0; pp = 0;
      if (evt && m_q.size() > 0 && !m_lock) begin
        if (m_q[0][DATA_W] && lmode) setl = 1; else pp = 1;
      end
      if (err_reset && m_lock) pp = 1;
      m_req = act && !evt && !m_lock && !setl && (m_q.size() > 0);
      if (pp) void'(m_q.pop_front());
      if (push && m_q.size() < DEPTH) m_q.push_back({push_err, push_data});
      if (setl) m_lock = 1;
      else if (err_reset && m_lock) m_lock = 0;
      m_rd_prev = rd_n;
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "req_n", req_n, !m_req);
    chk("R11", "count", count, m_q.size());
    chk("R11", "empty", empty, m_q.size() == 0);
    chk("R11", "full", full, m_q.size() == DEPTH);
    if (m_q.size() > 0) begin
      chk("R12", "rd_data", rd_data, m_q[0][DATA_W-1:0]);
      chk("R12", "rd_err", rd_err, m_q[0][DATA_W]);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic put(logic [7:0] d, logic e);
    push = 1; push_data = d; push_err = e; cyc(); push = 0; push_err = 0;
  endtask

  task automatic rd(logic s);
    rd_sel = s; rd_n = 0; cyc(); rd_n = 1; cyc(); rd_sel = 0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1; #1;
    cur_req = "R1";
    chk("R1", "req_n after reset", req_n, 1);
    chk("R1", "count after reset", count, 0);
    chk("R1", "empty after reset", empty, 1);
    cyc();

    cur_req = "R2";
    dma_ctrl = 3'b011; put(8'h11, 0); cyc(2);
    chk("R2", "not enabled", req_n, 1);
    dma_ctrl = 3'b101; cyc(2);
    chk("R2", "not selected", req_n, 1);

    cur_req = "R3";
    dma_ctrl = 3'b111; cyc();
    chk("R3", "enabled with data", req_n, 0);

    cur_req = "R5";
    rd(0);
    chk("R5", "unselected read count", count, 1);
    chk("R5", "unselected read req", req_n, 0);

    cur_req = "R11";
    put(8'h22, 0); put(8'h33, 0); put(8'h44, 0);
    chk("R11", "full count", count, 3);
    chk("R11", "full flag", full, 1);

    cur_req = "R4";
    rd_sel = 1; rd_n = 0; cyc();
    chk("R4", "req released", req_n, 1);
    chk("R4", "popped", count, 2);
    chk("R12", "new head", rd_data, 8'h22);
    cur_req = "R6";
    rd_n = 1; cyc();
    chk("R6", "re-asserted", req_n, 0);
    rd(1); rd(1); cyc();
    chk("R6", "drained", count, 0);

    cur_req = "R7";
    mode = 2'b01;
    put(8'h55, 1); put(8'h66, 0); cyc();
    chk("R7", "req before lock", req_n, 0);
    rd(1);
    chk("R7", "locked no pop", count, 2);
    chk("R7", "locked high", req_n, 1);
    chk("R12", "err flag", rd_err, 1);
    rd(1); cyc(3);
    chk("R7", "reread no pop", count, 2);
    chk("R7", "still high", req_n, 1);
    cur_req = "R8";
    err_reset = 1; cyc(); err_reset = 0;
    chk("R8", "err reset pops", count, 1);
    cyc();
    chk("R8", "follows again", req_n, 0);
    chk("R8", "next head", rd_data, 8'h66);
    err_reset = 1; cyc(); err_reset = 0;
    chk("R8", "reset unlocked no effect", count, 1);
    rd(1);

    cur_req = "R9";
    mode = 2'b10;
    put(8'h77, 1); cyc();
    rd(1);
    chk("R9", "flagged popped", count, 0);

    cur_req = "R10";
    mode = 2'b11;
    put(8'h88, 0); cyc();
    rd_sel = 1; rd_n = 0; push = 1; push_data = 8'h99; cyc();
    push = 0; rd_n = 1;
    chk("R10", "count kept", count, 1);
    chk("R10", "released", req_n, 1);
    cyc();
    chk("R10", "fresh edge", req_n, 0);
    rd(1); cyc();

    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      dma_ctrl  = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b111;
      if (i % 500 == 0) mode = 2'($urandom);
      push      = ($urandom_range(0, 3) == 0);
      push_data = 8'($urandom);
      push_err  = ($urandom_range(0, 4) == 0);
      rd_n      = ($urandom_range(0, 2) != 0);
      rd_sel    = ($urandom_range(0, 5) != 0);
      err_reset = ($urandom_range(0, 15) == 0);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule